// File: doc/BRIEF.md
# Channel Doorbell Transfer Ring Tracker

This block lives on the device side of a host-to-device link and tracks one circular transfer ring per logical channel. For every channel it holds a ring base address, the index of the last ring slot, a read index (RP) and a write index (WP). Configuration software loads all of these, together with an enable bit, through a single write port. After the host has placed a new element in a ring and moved its write index forward, it writes a doorbell. The doorbell carries the channel number and the new WP.

A channel has pending work when it is enabled and its RP differs from its WP. A round-robin arbiter selects one pending channel. It presents that channel's number and the byte address of the element at RP, which is the ring base plus RP shifted left by the element-size exponent. When the downstream consumer has taken that element it pulses `consume_i`, and the granted channel's RP moves forward by one, returning to zero after the last slot. A doorbell that would corrupt the ring is dropped and flagged. That covers two cases: a WP past the last slot, and a WP that lands on RP while the ring still holds data.

Top module: `ring_trk`

## Requirements
- R1: After reset `pend_o` is all zero, `gnt_valid_o` is 0 and `db_err_o` is 0.
- R2: A configuration write loads base, last-slot index, RP, WP and enable for channel `cfg_ch_i`. A channel is reported in `pend_o` (bit n for channel n) only while it is enabled and its RP differs from its WP, so a ring with RP equal to WP is empty.
- R3: An accepted doorbell replaces the channel's WP. The channel's `pend_o` bit follows the new WP from the cycle after the doorbell.
- R4: A doorbell whose new WP equals RP while RP differs from WP (the ring holds data) is ignored, and `db_err_o` is 1 for exactly the one cycle after it. The same WP value on an empty ring is accepted and raises no error.
- R5: A doorbell whose new WP is greater than the channel's last-slot index is ignored and raises `db_err_o` in the following cycle.
- R6: `gnt_valid_o` is 1 whenever any channel is pending. `gnt_ch_o` names a pending channel, and `gnt_addr_o` equals that channel's base plus RP times 2^ELEM_LOG2.
- R7: `consume_i` while `gnt_valid_o` is 1 advances the granted channel's RP by one, wrapping from the last-slot index to 0. The channel drops out of `pend_o` once RP reaches WP.
- R8: Arbitration is round-robin. After channel k is consumed, the next grant goes to the first pending channel found searching k+1, k+2, … cyclically. After reset the search starts at channel 0.
- R9: A doorbell that leaves the ring full (WP+1 modulo ring length equals RP) is accepted, so a ring of L slots can hold L-1 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | CH_W | Channel being configured |
| cfg_base_i | input | ADDR_W | Ring base byte address |
| cfg_last_i | input | PTR_W | Index of the last ring slot (ring length minus one) |
| cfg_rp_i | input | PTR_W | Initial read index |
| cfg_wp_i | input | PTR_W | Initial write index |
| cfg_en_i | input | 1 | Channel enable |
| db_we_i | input | 1 | Doorbell write strobe |
| db_ch_i | input | CH_W | Doorbell channel number |
| db_wp_i | input | PTR_W | New write index carried by the doorbell |
| pend_o | output | NUM_CH | Per-channel pending-work flags |
| gnt_valid_o | output | 1 | A channel is granted |
| gnt_ch_o | output | CH_W | Granted channel number |
| gnt_addr_o | output | ADDR_W | Byte address of the granted channel's element at RP |
| consume_i | input | 1 | Consumer took the granted element; advance its RP |
| db_err_o | output | 1 | One-cycle flag for a rejected doorbell |

## Verification
The hardest state to reach is a ring whose RP has wrapped past the last slot while its WP sits just behind it. Only in that state can the overflow rejection and the accepted full-ring doorbell be told apart. The stimulus builds it deliberately: a ring is configured with RP near its end, a wrapping doorbell moves WP to a low index, and consumes are interleaved with a second channel so that the round-robin pointer moves while RP crosses zero. Then the colliding doorbell and the full-ring doorbell are written. A final consume proves that the full-ring WP was kept, because the channel stays pending only if it was.

// File: rtl/ring_trk_pkg.sv
`timescale 1ns/1ps
package ring_trk_pkg;
  localparam int unsigned MAX_CHANNELS = 256;

  typedef enum logic [1:0] {
    DB_OK       = 2'd0,
    DB_OVERFLOW = 2'd1,
    DB_RANGE    = 2'd2
  } db_verdict_e;
endpackage

// File: rtl/ring_trk_chan.sv
`timescale 1ns/1ps
module ring_trk_chan
  import ring_trk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PTR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [PTR_W-1:0]  cfg_last_i,
  input  logic [PTR_W-1:0]  cfg_rp_i,
  input  logic [PTR_W-1:0]  cfg_wp_i,
  input  logic              cfg_en_i,
  input  logic              db_we_i,
  input  logic [PTR_W-1:0]  db_wp_i,
  input  logic              adv_i,
  output logic              pend_o,
  output db_verdict_e       verdict_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [PTR_W-1:0]  rp_o
);
  logic              en_q;
  logic [ADDR_W-1:0] base_q;
  logic [PTR_W-1:0]  last_q, rp_q, wp_q;

  assign pend_o = en_q && (rp_q != wp_q);
  assign base_o = base_q;
  assign rp_o   = rp_q;

  // Judged against the RP held before any same-cycle consume.
  always_comb begin
    if (db_wp_i > last_q)                        verdict_o = DB_RANGE;
    else if (db_wp_i == rp_q && rp_q != wp_q)    verdict_o = DB_OVERFLOW;
    else                                         verdict_o = DB_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= '0;
      last_q <= '0;
      rp_q   <= '0;
      wp_q   <= '0;
    end else if (cfg_we_i) begin
      en_q   <= cfg_en_i;
      base_q <= cfg_base_i;
      last_q <= cfg_last_i;
      rp_q   <= cfg_rp_i;
      wp_q   <= cfg_wp_i;
    end else begin
      if (adv_i && pend_o) rp_q <= (rp_q == last_q) ? '0 : rp_q + 1'b1;
      if (db_we_i && verdict_o == DB_OK) wp_q <= db_wp_i;
    end
  end
endmodule

// File: rtl/ring_trk_rr.sv
`timescale 1ns/1ps
module ring_trk_rr #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             adv_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] last_q;
  int unsigned cand;

  // Walk from farthest to nearest so the nearest requester after last_q wins.
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    cand    = 0;
    for (int i = N; i >= 1; i--) begin
      cand = int'(last_q) + i;
      if (cand >= N) cand = cand - N;
      if (req_i[cand]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               last_q <= IDX_W'(N - 1);
    else if (adv_i && valid_o) last_q <= idx_o;
  end
endmodule

// File: rtl/ring_trk.sv
`timescale 1ns/1ps
module ring_trk
  import ring_trk_pkg::*;
#(
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned PTR_W     = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ELEM_LOG2 = 4,
  localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [PTR_W-1:0]  cfg_last_i,
  input  logic [PTR_W-1:0]  cfg_rp_i,
  input  logic [PTR_W-1:0]  cfg_wp_i,
  input  logic              cfg_en_i,
  input  logic              db_we_i,
  input  logic [CH_W-1:0]   db_ch_i,
  input  logic [PTR_W-1:0]  db_wp_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic              gnt_valid_o,
  output logic [CH_W-1:0]   gnt_ch_o,
  output logic [ADDR_W-1:0] gnt_addr_o,
  input  logic              consume_i,
  output logic              db_err_o
);
  logic [ADDR_W-1:0] base_a    [NUM_CH];
  logic [PTR_W-1:0]  rp_a      [NUM_CH];
  db_verdict_e       verdict_a [NUM_CH];
  logic              take;
  logic              db_hit;
  logic              err_q;

  assign take = consume_i && gnt_valid_o;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ring_trk_chan #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i && cfg_ch_i == CH_W'(g)),
      .cfg_base_i (cfg_base_i),
      .cfg_last_i (cfg_last_i),
      .cfg_rp_i   (cfg_rp_i),
      .cfg_wp_i   (cfg_wp_i),
      .cfg_en_i   (cfg_en_i),
      .db_we_i    (db_we_i && db_ch_i == CH_W'(g)),
      .db_wp_i    (db_wp_i),
      .adv_i      (take && gnt_ch_o == CH_W'(g)),
      .pend_o     (pend_o[g]),
      .verdict_o  (verdict_a[g]),
      .base_o     (base_a[g]),
      .rp_o       (rp_a[g])
    );
  end

  ring_trk_rr #(.N(NUM_CH), .IDX_W(CH_W)) u_rr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (pend_o),
    .adv_i   (take),
    .valid_o (gnt_valid_o),
    .idx_o   (gnt_ch_o)
  );

  assign gnt_addr_o = base_a[gnt_ch_o] + (ADDR_W'(rp_a[gnt_ch_o]) << ELEM_LOG2);

  assign db_hit = db_we_i && (int'(db_ch_i) < NUM_CH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= db_hit && (verdict_a[db_ch_i] != DB_OK);
  end

  assign db_err_o = err_q;
endmodule

// File: rtl/ring_trk_chk.sv
`timescale 1ns/1ps
module ring_trk_chk #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              db_we_i,
  input logic [NUM_CH-1:0] pend_o,
  input logic              gnt_valid_o,
  input logic [CH_W-1:0]   gnt_ch_o,
  input logic              db_err_o
);
  // R6: grant always names a pending channel
  a_r6_gnt_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> pend_o[gnt_ch_o]);

  // R6: any pending channel produces a grant
  a_r6_gnt_when_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_o) |-> gnt_valid_o);

  // R4, R5: error flag only follows a doorbell
  a_r4_err_after_db: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_err_o |-> $past(db_we_i));

  // R3: new pending work only appears after a doorbell or configuration write
  a_r3_pend_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_o & ~$past(pend_o)) != '0) |-> $past(cfg_we_i || db_we_i));
endmodule

bind ring_trk ring_trk_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/ring_trk_bench.sv
`timescale 1ns/1ps
module ring_trk_bench;
  localparam int NUM_CH = 8;
  localparam int PTR_W  = 8;
  localparam int ADDR_W = 32;
  localparam int CH_W   = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_we_i = 1'b0, cfg_en_i = 1'b0;
  logic [CH_W-1:0]   cfg_ch_i = '0;
  logic [ADDR_W-1:0] cfg_base_i = '0;
  logic [PTR_W-1:0]  cfg_last_i = '0, cfg_rp_i = '0, cfg_wp_i = '0;
  logic              db_we_i = 1'b0;
  logic [CH_W-1:0]   db_ch_i = '0;
  logic [PTR_W-1:0]  db_wp_i = '0;
  logic              consume_i = 1'b0;
  logic [NUM_CH-1:0] pend_o;
  logic              gnt_valid_o;
  logic [CH_W-1:0]   gnt_ch_o;
  logic [ADDR_W-1:0] gnt_addr_o;
  logic              db_err_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ring_trk #(.NUM_CH(NUM_CH), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .ELEM_LOG2(4)) u_ring_trk (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i), .cfg_base_i(cfg_base_i),
    .cfg_last_i(cfg_last_i), .cfg_rp_i(cfg_rp_i), .cfg_wp_i(cfg_wp_i), .cfg_en_i(cfg_en_i),
    .db_we_i(db_we_i), .db_ch_i(db_ch_i), .db_wp_i(db_wp_i),
    .pend_o(pend_o), .gnt_valid_o(gnt_valid_o), .gnt_ch_o(gnt_ch_o),
    .gnt_addr_o(gnt_addr_o), .consume_i(consume_i), .db_err_o(db_err_o)
  );

  // op: 0 idle, 1 config (base=p0<<8, last=p1, rp=wp=p2, enabled), 2 doorbell (wp=p0), 3 consume
  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  ch;
    logic [7:0]  p0;
    logic [7:0]  p1;
    logic [7:0]  p2;
    logic [7:0]  pend;
    logic        gv;
    logic [2:0]  gch;
    logic [31:0] addr;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 3'd2, 8'h10, 8'd3, 8'd1, 8'h00, 1'b0, 3'd0, 32'h0,    1'b0, 4'd2}, // R2 ch2 empty
    '{2'd1, 3'd5, 8'h20, 8'd7, 8'd6, 8'h00, 1'b0, 3'd0, 32'h0,    1'b0, 4'd2}, // R2 ch5 empty
    '{2'd2, 3'd2, 8'd3,  8'd0, 8'd0, 8'h04, 1'b1, 3'd2, 32'h1010, 1'b0, 4'd3}, // R3 doorbell
    '{2'd2, 3'd5, 8'd1,  8'd0, 8'd0, 8'h24, 1'b1, 3'd2, 32'h1010, 1'b0, 4'd3}, // R3 wrapping WP
    '{2'd3, 3'd0, 8'd0,  8'd0, 8'd0, 8'h24, 1'b1, 3'd5, 32'h2060, 1'b0, 4'd8}, // R8 rotate
    '{2'd3, 3'd0, 8'd0,  8'd0, 8'd0, 8'h24, 1'b1, 3'd2, 32'h1020, 1'b0, 4'd8}, // R8 rotate back
    '{2'd3, 3'd0, 8'd0,  8'd0, 8'd0, 8'h20, 1'b1, 3'd5, 32'h2070, 1'b0, 4'd7}, // R7 ch2 drains
    '{2'd3, 3'd0, 8'd0,  8'd0, 8'd0, 8'h20, 1'b1, 3'd5, 32'h2000, 1'b0, 4'd7}, // R7 RP wraps
    '{2'd2, 3'd5, 8'd0,  8'd0, 8'd0, 8'h20, 1'b1, 3'd5, 32'h2000, 1'b1, 4'd4}, // R4 overflow
    '{2'd0, 3'd0, 8'd0,  8'd0, 8'd0, 8'h20, 1'b1, 3'd5, 32'h2000, 1'b0, 4'd4}, // R4 one-cycle flag
    '{2'd2, 3'd5, 8'd7,  8'd0, 8'd0, 8'h20, 1'b1, 3'd5, 32'h2000, 1'b0, 4'd9}, // R9 full accepted
    '{2'd2, 3'd2, 8'd4,  8'd0, 8'd0, 8'h20, 1'b1, 3'd5, 32'h2000, 1'b1, 4'd5}, // R5 past last slot
    '{2'd2, 3'd2, 8'd0,  8'd0, 8'd0, 8'h24, 1'b1, 3'd2, 32'h1030, 1'b0, 4'd3}, // R3 after R5 reject
    '{2'd3, 3'd0, 8'd0,  8'd0, 8'd0, 8'h20, 1'b1, 3'd5, 32'h2000, 1'b0, 4'd7}, // R7 wrap to empty
    '{2'd3, 3'd0, 8'd0,  8'd0, 8'd0, 8'h20, 1'b1, 3'd5, 32'h2010, 1'b0, 4'd9}, // R9 WP=7 kept
    '{2'd1, 3'd5, 8'h30, 8'd3, 8'd2, 8'h00, 1'b0, 3'd0, 32'h0,    1'b0, 4'd2}, // R2 reload
    '{2'd2, 3'd5, 8'd2,  8'd0, 8'd0, 8'h00, 1'b0, 3'd0, 32'h0,    1'b0, 4'd4}, // R4 empty, no error
    '{2'd2, 3'd5, 8'd3,  8'd0, 8'd0, 8'h20, 1'b1, 3'd5, 32'h3020, 1'b0, 4'd6}  // R6 address
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    cfg_we_i = 1'b0; db_we_i = 1'b0; consume_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pend", 64'(pend_o), 64'h0);
    check("R1 gnt_valid", 64'(gnt_valid_o), 64'h0);
    check("R1 db_err", 64'(db_err_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      string tag;
      v = VECS[k];
      case (v.op)
        2'd1: begin
          cfg_we_i = 1'b1; cfg_ch_i = v.ch; cfg_base_i = {16'h0, v.p0, 8'h00};
          cfg_last_i = v.p1; cfg_rp_i = v.p2; cfg_wp_i = v.p2; cfg_en_i = 1'b1;
        end
        2'd2: begin db_we_i = 1'b1; db_ch_i = v.ch; db_wp_i = v.p0; end
        2'd3: consume_i = 1'b1;
        default: ;
      endcase
      @(posedge clk);
      @(negedge clk);
      clear_inputs();
      tag = $sformatf("R%0d step%0d", v.req, k);
      check({tag, " pend"}, 64'(pend_o), 64'(v.pend));
      check({tag, " gnt_valid"}, 64'(gnt_valid_o), 64'(v.gv));
      if (v.gv) begin
        check({tag, " gnt_ch"}, 64'(gnt_ch_o), 64'(v.gch));
        check({tag, " gnt_addr"}, 64'(gnt_addr_o), 64'(v.addr));
      end
      check({tag, " db_err"}, 64'(db_err_o), 64'(v.err));
      @(negedge clk);
    end

    // R1: reset mid-run clears pending work
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 pend after reset", 64'(pend_o), 64'h0);
    check("R1 gnt_valid after reset", 64'(gnt_valid_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule